// File: doc/BRIEF.md
# Rising Edge Pulse Detector with Slow-Step State Machine

This block watches a single-bit level signal and produces a pulse when that signal goes from low to high. A three-state Moore machine does the detection. Its middle "just changed" state is the only state in which the pulse is driven, so each rising edge gives a pulse that lasts exactly one machine step.

The machine does not step on every system clock. A free-running prescaler of `DIV_W` bits produces a one-cycle enable once every 2^`DIV_W` system clocks, and the state register loads only on that enable. With the default width of 16, one step lasts long enough for the pulse to be seen on an indicator. The level input first passes through a two-flop synchronizer. A synchronous reset clears the prescaler and returns the machine to the idle state.

Top module: `edge_rise_detect`

## Requirements
- R1: The machine has three legal states, encoded LOW=2'b00, CHANGED=2'b01 and HIGH=2'b10. `pulse_o` is 1 only while the state is CHANGED.
- R2: At a step in state LOW, a synchronized level of 1 moves the machine to CHANGED, and a level of 0 keeps it in LOW.
- R3: At a step in state CHANGED, the machine moves to HIGH if the synchronized level is 1 and to LOW otherwise. Each pulse therefore lasts exactly one step (2^DIV_W clocks).
- R4: At a step in state HIGH, the machine stays in HIGH while the synchronized level is 1 and returns to LOW when it is 0. A level held high gives no further pulse.
- R5: The state changes only at the system clock edge where the one-cycle prescaler enable is high. The enable occurs once every 2^DIV_W clocks, the first time on the 2^DIV_W-th clock edge after reset is released.
- R6: `level_i` reaches the machine through a two-flop synchronizer. A change made less than two clocks before a step edge is not seen until the following step.
- R7: A pulse on `level_i` that starts and ends between two steps, and is not present at the synchronizer output at a step edge, causes no pulse.
- R8: A synchronous reset clears the prescaler, puts the machine in LOW and holds `pulse_o` at 0. The unused encoding 2'b11 leads back to LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| level_i | input | 1 | Asynchronous level to be watched |
| pulse_o | output | 1 | High for one step after a low-to-high change of the level |

## Verification
On every cycle, the assertions check these properties:
- the state holds between prescaler enables;
- the state never jumps from LOW straight to HIGH;
- CHANGED never lasts past one step;
- HIGH is kept while the synchronized level is high;
- the state never reaches the unused encoding;
- the enable wraps the prescaler and never fires twice in a row;
- the synchronizer delays a rise by exactly two clocks.

Only the bench scenarios can show the results that depend on timing across a whole step:
- the pulse appears on the expected step for a sequence of levels;
- a late input change is deferred to the next step;
- a glitch between steps is lost;
- reset in the middle of a pulse realigns the step grid.

// File: rtl/edge_pkg.sv
package edge_pkg;

    typedef enum logic [1:0] {
        ST_LOW     = 2'b00,
        ST_CHANGED = 2'b01,
        ST_HIGH    = 2'b10
    } edge_state_t;

    typedef struct packed {
        edge_state_t st;
    } fsm_regs_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) sh_q <= '0;
        else       sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R6: a rise at the output was present at the input two clocks earlier
            a_r6_two_clock_delay: assert property (@(posedge clk_i) disable iff (rst_i)
                $rose(q_o) |-> $past(d_i, 2));
        end
    endgenerate
endmodule

// File: rtl/edge_prescaler.sv
module edge_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign tick_o = &cnt_q;

    // R5: enable marks the wrap of the counter
    a_r5_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (cnt_q == '0));
    // R5: enable is a single-cycle event
    a_r5_single: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);
endmodule

// File: rtl/edge_fsm.sv
module edge_fsm
    import edge_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        step_i,
    input  logic        lvl_i,
    output edge_state_t st_o
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (step_i) begin
            case (r_q.st)
                ST_LOW:     r_d.st = lvl_i ? ST_CHANGED : ST_LOW;
                ST_CHANGED: r_d.st = lvl_i ? ST_HIGH    : ST_LOW;
                ST_HIGH:    r_d.st = lvl_i ? ST_HIGH    : ST_LOW;
                default:    r_d.st = ST_LOW;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q.st <= ST_LOW;
        else       r_q    <= r_d;
    end

    assign st_o = r_q.st;

    // R5: state holds between steps
    a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(r_q.st));
    // R2: never skip from LOW straight to HIGH
    a_r2_no_skip: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_LOW) |=> (r_q.st != ST_HIGH));
    // R3: CHANGED lasts a single step
    a_r3_one_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_CHANGED && step_i) |=> (r_q.st != ST_CHANGED));
    // R4: HIGH is kept while the level stays high
    a_r4_keep_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.st == ST_HIGH && step_i && lvl_i) |=> (r_q.st == ST_HIGH));
    // R8: unused encoding is never reached
    a_r8_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        r_q.st != 2'b11);
endmodule

// File: rtl/edge_rise_detect.sv
module edge_rise_detect
    import edge_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic pulse_o
);
    logic        lvl_sync;
    logic        step;
    edge_state_t st;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (level_i),
        .q_o   (lvl_sync)
    );

    edge_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (step)
    );

    edge_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (step),
        .lvl_i  (lvl_sync),
        .st_o   (st)
    );

    assign pulse_o = (st == ST_CHANGED);

    // R1: a new pulse starts only on a step edge
    a_r1_rise_on_step: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pulse_o) |-> $past(step));
endmodule

// File: tb/edge_rise_detect_tb.sv
`timescale 1ns/1ps
module edge_rise_detect_tb;
    localparam int DIV_W = 3;
    localparam int STEP  = 1 << DIV_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic level = 1'b0;
    logic pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_rise_detect #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .level_i (level),
        .pulse_o (pulse)
    );

    // level applied for one step, expected pulse after that step
    localparam int NV = 11;
    localparam logic [1:0] VEC [NV] = '{
        2'b00, 2'b11, 2'b10, 2'b10, 2'b00, 2'b11,
        2'b00, 2'b00, 2'b11, 2'b10, 2'b00
    };

    task automatic chk(input logic exp, input string req);
        checks++;
        if (pulse !== exp) begin
            errors++;
            $display("FAIL %s pulse=%b expected=%b at %0t", req, pulse, exp, $time);
        end
    endtask

    initial begin
        logic prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R8 reset");
        rst = 1'b0;

        // R1 R2 R3 R4 R5: table walk, one step per vector
        prev = 1'b0;
        for (int i = 0; i < NV; i++) begin
            level = VEC[i][1];
            repeat (STEP - 1) @(posedge clk);
            @(negedge clk);
            chk(prev, "R5 hold before step");
            @(posedge clk);
            @(negedge clk);
            chk(VEC[i][0], "R1-table R2 R3 R4");
            prev = VEC[i][0];
        end

        // R7: glitch between steps is lost
        @(posedge clk); @(negedge clk);
        level = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        level = 1'b0;
        repeat (STEP - 3) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R7 glitch");
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R7 glitch next step");

        // R6: late rise deferred one step
        repeat (STEP - 1) @(posedge clk);
        @(negedge clk);
        level = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(1'b0, "R6 late rise");
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk(1'b1, "R6 deferred pulse R2");
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R3 pulse one step");

        // R4: level held, back low
        level = 1'b0;
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R4 back to low");

        // R8: reset in the middle of a pulse
        level = 1'b1;
        repeat (STEP) @(posedge clk);
        @(negedge clk);
        chk(1'b1, "R2 rise before reset");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(1'b0, "R8 reset clears pulse");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (STEP - 1) @(posedge clk);
        @(negedge clk);
        chk(1'b0, "R5 R8 prescaler restarted");
        @(posedge clk); @(negedge clk);
        chk(1'b1, "R5 R8 first step after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule